// File: doc/BRIEF.md
# Selectable CRC and Parity Receive Checker

This block judges the integrity of received data as it arrives one bit at a time. A two-bit mode input selects one of three checks: a 16-bit CRC on the CCITT polynomial, a 16-bit CRC on the CRC-16 polynomial, or a parity check on each character. The receive path supplies each data bit with a valid strobe. It raises a start pulse when a new frame begins, and a sample pulse when the frame ends or a character is complete. The block turns what it has accumulated into a single registered error flag. That flag keeps its value until the next sample pulse.

For the CCITT check, the register is preset at frame start to all ones or to all zeros, chosen by a control input. For CRC-16, it is always preset to zeros. Both CRCs shift least significant bit first. The two CRCs report in opposite senses. In CCITT mode the flag is 1 on a bad frame. In CRC-16 mode the flag is 1 when the frame checks good. In parity mode the flag is 1 on a parity error. Parity is taken over every bit of the character, including the parity bit itself. The parity accumulator starts afresh after each sample pulse, so each character is judged on its own.

Top module: `rx_err_check`

## Requirements
- R1: After reset, and again after any later reset, `errFlag` is 0.
- R2: With `modeSel` = 2'b00 and `ccittOnes` = 1, the register is preset to 16'hFFFF. Bits are folded in least significant bit first with the reflected polynomial 16'h8408. On a sample pulse, `errFlag` becomes 1 if the register differs from 16'hF0B8 and 0 if it equals it. A frame whose two trailing bytes carry the complemented CRC, low byte first, gives 0.
- R3: With `modeSel` = 2'b00 and `ccittOnes` = 0, the preset is 16'h0000. On a sample pulse, `errFlag` becomes 1 unless the register is 0. A frame followed by its uncomplemented CRC, low byte first, gives 0.
- R4: With `modeSel` = 2'b01, the preset is 16'h0000 and the reflected polynomial is 16'hA001. On a sample pulse, `errFlag` becomes 1 when the register is 0 (good frame) and 0 when it is nonzero (bad frame).
- R5: With `modeSel[1]` = 1, a sample pulse sets `errFlag` to the XOR of all bits of the character, XORed with `parityOdd`. With `parityOdd` = 0, even parity is expected. With `parityOdd` = 1, odd parity is expected.
- R6: In parity mode, each sample pulse clears the parity accumulator, so the next character is judged only on its own bits.
- R7: `errFlag` changes only on the clock edge that follows a cycle with `sampleNow` high. Bits and frame starts without a sample leave it unchanged.
- R8: A bit whose `bitValid` cycle coincides with `sampleNow` is included in the judgement made by that sample.
- R9: `frameStart` presets the CRC register and clears the parity accumulator. A bit presented in the same cycle is discarded. A sample in the same cycle judges the freshly preset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 00 CCITT CRC, 01 CRC-16, 1x parity |
| ccittOnes | input | 1 | CCITT preset: 1 all ones, 0 all zeros |
| parityOdd | input | 1 | Parity sense: 1 odd, 0 even |
| frameStart | input | 1 | Start-of-frame pulse; presets the check state |
| bitValid | input | 1 | Strobe qualifying `bitIn` |
| bitIn | input | 1 | Received serial bit |
| sampleNow | input | 1 | End-of-frame or character-complete sample pulse |
| errFlag | output | 1 | Registered error indicator, mode-specific sense |

## Verification
A sample pulse can fall in the same cycle as the shift of the last bit. Every table vector provokes this by raising `sampleNow` together with the final FCS bit or the final character bit. If the flag is right, the judgement was made on the post-shift value. A frame start can also coincide with a sample pulse or with a valid bit. Directed tests drive both collisions after forcing the flag to the opposite value. They judge that the sample sees a freshly preset register and that the colliding bit is dropped.

// File: rtl/rx_err_check_pkg.sv
package rx_err_check_pkg;

  typedef enum logic [1:0] {
    JUDGE_CCITT = 2'd0,
    JUDGE_CRC16 = 2'd1,
    JUDGE_PAR   = 2'd2
  } judge_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   preset;    // load preset value, drop any bit this cycle
    logic   onesSel;   // CCITT ones preset / F0B8 residue
    logic   shift;     // fold bitIn into CRC and parity
    logic   polySel;   // 0: CCITT polynomial, 1: CRC-16 polynomial
    logic   capture;   // update errFlag
    logic   clearPar;  // clear parity accumulator after capture
    logic   oddSense;  // parity sense
    judge_e judge;     // which comparison drives errFlag
  } dp_ctl_t;

endpackage

// File: rtl/rx_err_check_ctrl.sv
module rx_err_check_ctrl
  import rx_err_check_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       ccittOnes,
  input  logic       parityOdd,
  input  logic       frameStart,
  input  logic       bitValid,
  input  logic       sampleNow,
  output dp_ctl_t    ctl
);

  always_comb begin
    ctl          = '0;
    ctl.preset   = frameStart;
    ctl.shift    = bitValid & ~frameStart;
    ctl.capture  = sampleNow;
    ctl.oddSense = parityOdd;
    case (modeSel)
      2'b00: begin
        ctl.judge   = JUDGE_CCITT;
        ctl.polySel = 1'b0;
        ctl.onesSel = ccittOnes;
      end
      2'b01: begin
        ctl.judge   = JUDGE_CRC16;
        ctl.polySel = 1'b1;
        ctl.onesSel = 1'b0;
      end
      default: begin
        ctl.judge    = JUDGE_PAR;
        ctl.polySel  = 1'b0;
        ctl.onesSel  = 1'b0;
        ctl.clearPar = sampleNow;
      end
    endcase
  end

endmodule

// File: rtl/rx_err_check_dp.sv
module rx_err_check_dp
  import rx_err_check_pkg::*;
#(
  parameter int                 CRC_W         = 16,
  parameter logic [CRC_W-1:0]   POLY_CCITT    = 16'h8408,
  parameter logic [CRC_W-1:0]   POLY_C16      = 16'hA001,
  parameter logic [CRC_W-1:0]   RESIDUE_CCITT = 16'hF0B8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  input  logic             bitIn,
  output logic             errFlag,
  output logic [CRC_W-1:0] crcState,
  output logic             parState
);

  localparam int                 NUM_POLY = 2;
  localparam logic [NUM_POLY*CRC_W-1:0] POLY_SET = {POLY_C16, POLY_CCITT};

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcUpd;
  logic [CRC_W-1:0] stepOut [NUM_POLY];
  logic             parReg;
  logic             parUpd;
  logic             fbBit;
  logic             judgeErr;

  assign fbBit = crcReg[0] ^ bitIn;

  // one LSB-first shift engine per polynomial
  for (genvar g = 0; g < NUM_POLY; g++) begin : g_engine
    assign stepOut[g] = {1'b0, crcReg[CRC_W-1:1]}
                      ^ ({CRC_W{fbBit}} & POLY_SET[g*CRC_W +: CRC_W]);
  end

  always_comb begin
    crcUpd = crcReg;
    parUpd = parReg;
    if (ctl.preset) begin
      crcUpd = ctl.onesSel ? '1 : '0;
      parUpd = 1'b0;
    end else if (ctl.shift) begin
      crcUpd = stepOut[ctl.polySel];
      parUpd = parReg ^ bitIn;
    end
  end

  // judgement is made on the value after this cycle's update
  always_comb begin
    case (ctl.judge)
      JUDGE_CCITT: judgeErr = crcUpd != (ctl.onesSel ? RESIDUE_CCITT : '0);
      JUDGE_CRC16: judgeErr = crcUpd == '0;
      default:     judgeErr = parUpd ^ ctl.oddSense;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '0;
      parReg  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      crcReg <= crcUpd;
      parReg <= ctl.clearPar ? 1'b0 : parUpd;
      if (ctl.capture) errFlag <= judgeErr;
    end
  end

  assign crcState = crcReg;
  assign parState = parReg;

endmodule

// File: rtl/rx_err_check.sv
module rx_err_check
  import rx_err_check_pkg::*;
#(
  parameter int               CRC_W         = 16,
  parameter logic [CRC_W-1:0] POLY_CCITT    = 16'h8408,
  parameter logic [CRC_W-1:0] POLY_C16      = 16'hA001,
  parameter logic [CRC_W-1:0] RESIDUE_CCITT = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       ccittOnes,
  input  logic       parityOdd,
  input  logic       frameStart,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       sampleNow,
  output logic       errFlag
);

  dp_ctl_t          ctl;
  logic [CRC_W-1:0] crcState;
  logic             parState;

  rx_err_check_ctrl u_ctrl (
    .modeSel    (modeSel),
    .ccittOnes  (ccittOnes),
    .parityOdd  (parityOdd),
    .frameStart (frameStart),
    .bitValid   (bitValid),
    .sampleNow  (sampleNow),
    .ctl        (ctl)
  );

  rx_err_check_dp #(
    .CRC_W         (CRC_W),
    .POLY_CCITT    (POLY_CCITT),
    .POLY_C16      (POLY_C16),
    .RESIDUE_CCITT (RESIDUE_CCITT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bitIn    (bitIn),
    .errFlag  (errFlag),
    .crcState (crcState),
    .parState (parState)
  );

endmodule

// File: rtl/rx_err_check_sva.sv
module rx_err_check_sva #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             ccittOnes,
  input logic             parityOdd,
  input logic             frameStart,
  input logic             bitValid,
  input logic             sampleNow,
  input logic             errFlag,
  input logic [CRC_W-1:0] crcState,
  input logic             parState
);

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleNow |=> $stable(errFlag));

  p_ones_preset_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && modeSel == 2'b00 && ccittOnes |=> crcState == '1);

  p_zero_preset_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && modeSel == 2'b01 |=> crcState == '0);

  p_start_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && sampleNow && modeSel == 2'b01 |=> errFlag);

  p_parity_judge_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleNow && modeSel[1] && !bitValid && !frameStart
      |=> errFlag == ($past(parState) ^ $past(parityOdd)));

  p_parity_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleNow && modeSel[1] |=> !parState);

endmodule

bind rx_err_check rx_err_check_sva #(.CRC_W(CRC_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .ccittOnes  (ccittOnes),
  .parityOdd  (parityOdd),
  .frameStart (frameStart),
  .bitValid   (bitValid),
  .sampleNow  (sampleNow),
  .errFlag    (errFlag),
  .crcState   (crcState),
  .parState   (parState)
);

// File: tb/rx_err_check_bench.sv
`timescale 1ns/1ps
module rx_err_check_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       ccittOnes = 1'b0;
  logic       parityOdd = 1'b0;
  logic       frameStart = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       sampleNow = 1'b0;
  logic       errFlag;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  rx_err_check u_rx_err_check (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .ccittOnes(ccittOnes),
    .parityOdd(parityOdd), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .sampleNow(sampleNow), .errFlag(errFlag)
  );

  // {mode[1:0], ones, odd, data[23:0], fcsMask[15:0], expected}
  localparam int NV = 11;
  localparam logic [44:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b0, 24'h123456, 16'h0000, 1'b0},
    {2'b00, 1'b1, 1'b0, 24'hA5C3FF, 16'h0001, 1'b1},
    {2'b00, 1'b0, 1'b0, 24'h0F1E2D, 16'h0000, 1'b0},
    {2'b00, 1'b0, 1'b0, 24'h0F1E2D, 16'h8000, 1'b1},
    {2'b01, 1'b0, 1'b0, 24'h313233, 16'h0000, 1'b1},
    {2'b01, 1'b0, 1'b0, 24'h313233, 16'h0100, 1'b0},
    {2'b01, 1'b0, 1'b0, 24'h000000, 16'h0000, 1'b1},
    {2'b10, 1'b0, 1'b0, 24'h000003, 16'h0000, 1'b0},
    {2'b10, 1'b0, 1'b0, 24'h000007, 16'h0000, 1'b1},
    {2'b11, 1'b0, 1'b1, 24'h000007, 16'h0000, 1'b0},
    {2'b10, 1'b0, 1'b1, 24'h000081, 16'h0000, 1'b1}
  };

  function automatic logic [15:0] benchCrc(input logic [15:0] init,
                                           input logic [15:0] poly,
                                           input logic [23:0] d);
    logic [15:0] c;
    c = init;
    for (int i = 0; i < 24; i++) begin
      logic f;
      f = c[0] ^ d[i];
      c = c >> 1;
      if (f) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic checkFlag(input logic exp, input string tag);
    nChecks++;
    if (errFlag !== exp) begin
      nErrors++;
      $display("FAIL %s: errFlag actual %0b expected %0b", tag, errFlag, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic smp);
    bitIn = b; bitValid = 1'b1; sampleNow = smp;
    @(negedge clk);
    bitIn = 1'b0; bitValid = 1'b0; sampleNow = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] c, input logic smpLast);
    for (int i = 0; i < 8; i++) sendBit(c[i], smpLast && i == 7);
  endtask

  task automatic samplePulse();
    sampleNow = 1'b1;
    @(negedge clk);
    sampleNow = 1'b0;
  endtask

  task automatic frameBegin(input logic withBit, input logic withSample);
    frameStart = 1'b1; bitValid = withBit; bitIn = withBit; sampleNow = withSample;
    @(negedge clk);
    frameStart = 1'b0; bitValid = 1'b0; bitIn = 1'b0; sampleNow = 1'b0;
  endtask

  // CRC frame: 3 data bytes then FCS, sample on last FCS bit (R8 collision)
  task automatic crcFrame(input logic [1:0] m, input logic ones,
                          input logic [23:0] d, input logic [15:0] mask);
    logic [15:0] c;
    logic [15:0] fcs;
    modeSel = m; ccittOnes = ones;
    if (m == 2'b00) begin
      c   = benchCrc(ones ? 16'hFFFF : 16'h0000, 16'h8408, d);
      fcs = ones ? ~c : c;
    end else begin
      c   = benchCrc(16'h0000, 16'hA001, d);
      fcs = c;
    end
    fcs = fcs ^ mask;
    frameBegin(1'b0, 1'b0);
    for (int i = 0; i < 24; i++) sendBit(d[i], 1'b0);
    for (int i = 0; i < 16; i++) sendBit(fcs[i], i == 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkFlag(1'b0, "R1 reset value");

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      string tag;
      e = VEC[v];
      parityOdd = e[41];
      if (e[44]) begin
        modeSel = e[44:43];
        frameBegin(1'b0, 1'b0);
        sendChar(e[24:17], 1'b1);
        tag = "R5 R8 parity vector";
      end else begin
        crcFrame(e[44:43], e[42], e[40:17], e[16:1]);
        tag = (e[44:43] == 2'b01) ? "R4 R8 crc16 vector" :
              (e[42] ? "R2 R8 ccitt ones vector" : "R3 R8 ccitt zeros vector");
      end
      checkFlag(e[0], $sformatf("%s %0d", tag, v));
    end

    // R7: flag holds across bits and frame start without sample
    modeSel = 2'b10; parityOdd = 1'b0;
    frameBegin(1'b0, 1'b0);
    sendChar(8'h01, 1'b1);
    checkFlag(1'b1, "R5 single one even parity");
    sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0); sendBit(1'b1, 1'b0);
    checkFlag(1'b1, "R7 hold over unsampled bits");
    frameBegin(1'b0, 1'b0);
    checkFlag(1'b1, "R7 hold over frame start");

    // R6: each character judged alone
    sendChar(8'h03, 1'b1);
    checkFlag(1'b0, "R6 first char good");
    sendChar(8'h01, 1'b1);
    checkFlag(1'b1, "R6 second char bad");
    sendChar(8'h03, 1'b1);
    checkFlag(1'b0, "R6 third char good after bad");

    // R8: sample alone after seven bits
    frameBegin(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) sendBit(i == 0, 1'b0);
    samplePulse();
    checkFlag(1'b1, "R8 standalone sample judges seven bits");
    sendBit(1'b1, 1'b0);
    checkFlag(1'b1, "R7 unsampled bit leaves flag");

    // R9: bit in the frame-start cycle is dropped
    crcFrame(2'b01, 1'b0, 24'h313233, 16'h0100);
    checkFlag(1'b0, "R4 bad crc16 frame");
    frameBegin(1'b1, 1'b0);
    samplePulse();
    checkFlag(1'b1, "R9 bit with frame start dropped");
    crcFrame(2'b01, 1'b0, 24'h313233, 16'h0001);
    checkFlag(1'b0, "R4 bad crc16 frame again");
    frameBegin(1'b0, 1'b1);
    checkFlag(1'b1, "R9 sample with frame start sees preset");

    // R2 boundary: empty ones-preset frame is bad, re-preset after it
    crcFrame(2'b00, 1'b1, 24'hCAFE01, 16'h0000);
    checkFlag(1'b0, "R2 good ccitt frame");
    frameBegin(1'b0, 1'b0);
    samplePulse();
    checkFlag(1'b1, "R2 empty frame FFFF is not F0B8");
    crcFrame(2'b00, 1'b1, 24'hCAFE01, 16'h0000);
    checkFlag(1'b0, "R9 re-preset gives good frame");

    // R1: reset clears a set flag
    frameBegin(1'b0, 1'b1);
    checkFlag(1'b1, "R2 flag set before reset");
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkFlag(1'b0, "R1 reset clears flag");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule